// File: doc/BRIEF.md
# Gated Conversion Queue Sequencer

This block runs a short list of conversion commands against an external analog-to-digital converter. Each command word names an input channel and carries a hold bit. The sequencer takes the words in index order. For each word it sends a one-cycle start request with the channel number. It then waits for the converter's end-of-conversion pulse and stores the returned sample in the result slot whose index matches the command word.

A gate input level enables the queue. In single-scan mode a pass runs once, only while the scan-enable bit is armed, and the pass disarms that bit when it ends. In continuous mode the queue restarts from word 0 after every pass for as long as the gate stays open.

Closing the gate stops the queue after any conversion already in flight has finished. Reopening the gate always restarts from word 0. Two pointers are visible:
- a current pointer, naming the word being worked on;
- a completed pointer, naming the word whose result was written last.

Three sticky status flags report pass completion, an interrupted single pass and a repeated pass within one gate window.

Top module: `adcq_sequencer`

## Requirements
- R1: Conversions start from word 0 and follow word index order. Each start is a single-cycle `convStart` pulse with `convChan` equal to bits [CHAN_W-1:0] of the word. No new start is issued while a conversion is outstanding.
- R2: The result returned for command word N is stored in result slot N and can be read through `resRdAddr`/`resRdData`.
- R3: When bit CHAN_W (the hold bit) of a word is 1, the queue stops after that word's conversion until a `trigIn` pulse arrives. A `trigIn` that arrives while the queue is not holding has no effect.
- R4: `donePtr` changes only on an end-of-conversion, and it takes the index of the word just written. After a pass, and while holding, `curPtr` equals `donePtr`.
- R5: A pass ends at the first word whose channel field is all ones (the end marker, never converted), or after word NUM_CMDS-1. If word 0 is the marker, the pass is empty and completes at once.
- R6: In single-scan mode (`modeCont`=0) a pass runs only while `sseActive` is set, which `sseSet` arms. When the pass finishes, `cmpFlag` sets, `sseActive` clears and no further conversions start.
- R7: When the gate closes, a conversion in flight completes and its result is stored, then the queue goes idle. When the gate reopens, the next conversion uses word 0.
- R8: In single-scan mode, `pauseFlag` sets when the gate closes before the pass completes. In continuous mode it never sets.
- R9: In continuous mode (`modeCont`=1), `cmpFlag` sets at the end of every pass, and the next pass begins at word 0 while the gate stays open.
- R10: `torFlag` sets when a second pass completes within one continuous gate-open window. It stays clear after only one pass.
- R11: The flags are sticky. Pulsing `flagClr` bit 0 clears `cmpFlag`, bit 1 clears `pauseFlag` and bit 2 clears `torFlag`. Clearing one flag leaves the others unchanged, and a set in the same cycle wins over a clear.
- R12: After reset the block is idle and `convStart` is low. The pointers, flags, `sseActive` and all result slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWrAddr | input | PTR_W | Command word index to write |
| cmdWrData | input | CHAN_W+1 | {hold bit, channel} |
| modeCont | input | 1 | 1 = continuous scan, 0 = single scan |
| sseSet | input | 1 | Arms single-scan enable |
| gateIn | input | 1 | External gate level, high enables the queue |
| trigIn | input | 1 | Resume pulse for a holding queue |
| flagClr | input | 3 | Write-one-to-clear strobes {tor, pause, cmp} |
| convStart | output | 1 | Start-conversion pulse |
| convChan | output | CHAN_W | Channel for the conversion being started |
| convEoc | input | 1 | End-of-conversion pulse |
| convResult | input | RES_W | Sample valid with `convEoc` |
| resRdAddr | input | PTR_W | Result slot read index |
| resRdData | output | RES_W | Result slot contents |
| curPtr | output | PTR_W | Current command pointer |
| donePtr | output | PTR_W | Completed command pointer |
| busy | output | 1 | Queue active |
| sseActive | output | 1 | Single-scan enable state |
| cmpFlag | output | 1 | Pass completed |
| pauseFlag | output | 1 | Single pass cut short by the gate |
| torFlag | output | 1 | Repeated pass in one gate window |

## Verification
The main flow is driven by four patterns:
- Queues of random length with random channels and converter latencies, where the issued channel order and the slot contents show whether the words are indexed correctly and whether the marker and the top-of-memory end are detected.
- A queue with a hold bit in the middle, which shows whether the held position, the pointer relationship and the trigger resumption behave, and whether a trigger outside a hold is ignored.
- A gate that drops during a conversion and then reopens, which shows whether the in-flight result is kept, whether the restart goes to word 0 and whether the interruption flag sets.
- A continuous run left open across two passes, with an empty queue as a corner case, which shows the difference between a single completion and a repeated completion and how selective flag clearing works.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_HOLD
  } seqState_t;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic startPass;  // curPtr back to word 0
    logic advance;    // curPtr + 1
    logic issue;      // start a conversion of curPtr
    logic writeRes;   // store convResult in slot curPtr
    logic setCmp;
    logic setPause;
    logic setTor;
    logic clearSse;
  } seqStrobes_t;

endpackage

// File: rtl/adcq_datapath.sv
module adcq_datapath
  import adcq_pkg::*;
#(
  parameter int NUM_CMDS = 8,
  parameter int CHAN_W   = 4,
  parameter int RES_W    = 10,
  localparam int PTR_W   = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1,
  localparam int WORD_W  = CHAN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       strb,
  input  logic              cmdWrEn,
  input  logic [PTR_W-1:0]  cmdWrAddr,
  input  logic [WORD_W-1:0] cmdWrData,
  input  logic              sseSet,
  input  logic [2:0]        flagClr,
  input  logic [RES_W-1:0]  convResult,
  input  logic [PTR_W-1:0]  resRdAddr,
  output logic [RES_W-1:0]  resRdData,
  output logic [CHAN_W-1:0] curChan,
  output logic              curPause,
  output logic              curMarker,
  output logic              curIsLast,
  output logic [PTR_W-1:0]  curPtr,
  output logic [PTR_W-1:0]  donePtr,
  output logic              sseActive,
  output logic [2:0]        flagQ
);

  localparam logic [CHAN_W-1:0] MARKER  = {CHAN_W{1'b1}};
  localparam logic [PTR_W-1:0]  TOP_IDX = PTR_W'(NUM_CMDS - 1);

  logic [WORD_W-1:0] cmdMem [NUM_CMDS];
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] nextWord;
  logic [PTR_W-1:0]  ptrNext;
  logic [NUM_CMDS-1:0][RES_W-1:0] resFlat;
  logic [2:0] setVec;

  // Command memory resets to end markers, so the queue starts out empty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CMDS; i++) cmdMem[i] <= {1'b0, MARKER};
    end else if (cmdWrEn && (32'(cmdWrAddr) < NUM_CMDS)) begin
      cmdMem[cmdWrAddr] <= cmdWrData;
    end
  end

  assign ptrNext   = curPtr + 1'b1;
  assign curWord   = cmdMem[curPtr];
  assign nextWord  = (curPtr == TOP_IDX) ? {1'b0, MARKER} : cmdMem[ptrNext];
  assign curChan   = curWord[CHAN_W-1:0];
  assign curPause  = curWord[CHAN_W];
  assign curMarker = (curWord[CHAN_W-1:0] == MARKER);
  assign curIsLast = (curPtr == TOP_IDX) || (nextWord[CHAN_W-1:0] == MARKER);

  // Current and completed pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPtr  <= '0;
      donePtr <= '0;
    end else begin
      if (strb.startPass)    curPtr <= '0;
      else if (strb.advance) curPtr <= ptrNext;
      if (strb.writeRes)     donePtr <= curPtr;
    end
  end

  // One register per result slot
  for (genvar s = 0; s < NUM_CMDS; s++) begin : g_slot
    logic [RES_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slotQ <= '0;
      else if (strb.writeRes && (curPtr == PTR_W'(s))) slotQ <= convResult;
    end
    assign resFlat[s] = slotQ;
  end

  assign resRdData = (32'(resRdAddr) < NUM_CMDS) ? resFlat[resRdAddr] : '0;

  // Sticky flags {tor, pause, cmp}; a set wins over a clear.
  assign setVec = {strb.setTor, strb.setPause, strb.setCmp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flagQ <= '0;
    else        flagQ <= (flagQ & ~flagClr) | setVec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sseActive <= 1'b0;
    else if (sseSet)        sseActive <= 1'b1;
    else if (strb.clearSse) sseActive <= 1'b0;
  end

endmodule

// File: rtl/adcq_control.sv
module adcq_control
  import adcq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gateIn,
  input  logic        modeCont,
  input  logic        trigIn,
  input  logic        convEoc,
  input  logic        sseActive,
  input  logic        curPause,
  input  logic        curMarker,
  input  logic        curIsLast,
  output seqStrobes_t strb,
  output logic        busy
);

  seqState_t state, stateN;
  logic passSeen, passSeenN;
  logic finish, quit;
  logic runEn;

  assign runEn = gateIn && (modeCont || sseActive);

  always_comb begin
    strb      = '0;
    stateN    = state;
    passSeenN = passSeen;
    finish    = 1'b0;
    quit      = 1'b0;

    case (state)
      ST_IDLE: begin
        passSeenN = 1'b0;
        if (runEn) begin
          strb.startPass = 1'b1;
          stateN = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (!gateIn)        quit = 1'b1;
        else if (curMarker) finish = 1'b1;
        else begin
          strb.issue = 1'b1;
          stateN = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (convEoc) begin
          strb.writeRes = 1'b1;
          if (curPause) begin
            if (gateIn) stateN = ST_HOLD;
            else        quit = 1'b1;
          end else if (curIsLast) begin
            finish = 1'b1;
          end else if (!gateIn) begin
            quit = 1'b1;
          end else begin
            strb.advance = 1'b1;
            stateN = ST_ISSUE;
          end
        end
      end
      ST_HOLD: begin
        if (!gateIn) quit = 1'b1;
        else if (trigIn) begin
          if (curIsLast) finish = 1'b1;
          else begin
            strb.advance = 1'b1;
            stateN = ST_ISSUE;
          end
        end
      end
      default: stateN = ST_IDLE;
    endcase

    if (quit) begin
      stateN        = ST_IDLE;
      strb.setPause = !modeCont;
    end

    if (finish) begin
      strb.setCmp = 1'b1;
      strb.setTor = modeCont && passSeen;
      passSeenN   = 1'b1;
      if (!modeCont) begin
        strb.clearSse = 1'b1;
        stateN = ST_IDLE;
      end else if (gateIn) begin
        strb.startPass = 1'b1;
        stateN = ST_ISSUE;
      end else begin
        stateN = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      passSeen <= 1'b0;
    end else begin
      state    <= stateN;
      passSeen <= passSeenN;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/adcq_sequencer.sv
module adcq_sequencer
  import adcq_pkg::*;
#(
  parameter int NUM_CMDS = 8,
  parameter int CHAN_W   = 4,
  parameter int RES_W    = 10,
  localparam int PTR_W   = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWrEn,
  input  logic [PTR_W-1:0]  cmdWrAddr,
  input  logic [CHAN_W:0]   cmdWrData,
  input  logic              modeCont,
  input  logic              sseSet,
  input  logic              gateIn,
  input  logic              trigIn,
  input  logic [2:0]        flagClr,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  input  logic              convEoc,
  input  logic [RES_W-1:0]  convResult,
  input  logic [PTR_W-1:0]  resRdAddr,
  output logic [RES_W-1:0]  resRdData,
  output logic [PTR_W-1:0]  curPtr,
  output logic [PTR_W-1:0]  donePtr,
  output logic              busy,
  output logic              sseActive,
  output logic              cmpFlag,
  output logic              pauseFlag,
  output logic              torFlag
);

  seqStrobes_t strb;
  logic curPause, curMarker, curIsLast;
  logic [2:0] flagQ;

  adcq_control u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gateIn    (gateIn),
    .modeCont  (modeCont),
    .trigIn    (trigIn),
    .convEoc   (convEoc),
    .sseActive (sseActive),
    .curPause  (curPause),
    .curMarker (curMarker),
    .curIsLast (curIsLast),
    .strb      (strb),
    .busy      (busy)
  );

  adcq_datapath #(
    .NUM_CMDS (NUM_CMDS),
    .CHAN_W   (CHAN_W),
    .RES_W    (RES_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .cmdWrEn    (cmdWrEn),
    .cmdWrAddr  (cmdWrAddr),
    .cmdWrData  (cmdWrData),
    .sseSet     (sseSet),
    .flagClr    (flagClr),
    .convResult (convResult),
    .resRdAddr  (resRdAddr),
    .resRdData  (resRdData),
    .curChan    (convChan),
    .curPause   (curPause),
    .curMarker  (curMarker),
    .curIsLast  (curIsLast),
    .curPtr     (curPtr),
    .donePtr    (donePtr),
    .sseActive  (sseActive),
    .flagQ      (flagQ)
  );

  assign convStart = strb.issue;
  assign cmpFlag   = flagQ[0];
  assign pauseFlag = flagQ[1];
  assign torFlag   = flagQ[2];

endmodule

// File: rtl/adcq_checker.sv
module adcq_checker #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             convStart,
  input logic             convEoc,
  input logic             busy,
  input logic [PTR_W-1:0] donePtr,
  input logic             sseActive,
  input logic             cmpFlag,
  input logic             pauseFlag,
  input logic             torFlag,
  input logic [2:0]       flagClr,
  input logic             modeCont,
  input logic             gateIn
);

  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         outstanding <= 1'b0;
    else if (convStart) outstanding <= 1'b1;
    else if (convEoc)   outstanding <= 1'b0;
  end

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |=> !convStart);

  // R1
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |-> (!outstanding && busy));

  // R4
  done_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !convEoc |=> $stable(donePtr));

  // R6
  sse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sseActive) |-> cmpFlag);

  // R8
  pause_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pauseFlag) |-> (!$past(modeCont) && !$past(gateIn)));

  // R10
  tor_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(torFlag) |-> (cmpFlag && $past(modeCont)));

  // R11
  cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpFlag && !flagClr[0]) |=> cmpFlag);

endmodule

bind adcq_sequencer adcq_checker #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .convStart (convStart),
  .convEoc   (convEoc),
  .busy      (busy),
  .donePtr   (donePtr),
  .sseActive (sseActive),
  .cmpFlag   (cmpFlag),
  .pauseFlag (pauseFlag),
  .torFlag   (torFlag),
  .flagClr   (flagClr),
  .modeCont  (modeCont),
  .gateIn    (gateIn)
);

// File: tb/tb_adcq_sequencer.sv
`timescale 1ns/100ps
module tb_adcq_sequencer;

  localparam int NC = 8;
  localparam int CW = 4;
  localparam int RW = 10;
  localparam int PW = 3;
  localparam logic [CW-1:0] MRK = 4'hF;

  logic clk = 0, rst_n = 0;
  logic cmdWrEn = 0;
  logic [PW-1:0] cmdWrAddr = 0;
  logic [CW:0] cmdWrData = 0;
  logic modeCont = 0, sseSet = 0, gateIn = 0, trigIn = 0;
  logic [2:0] flagClr = 0;
  logic convStart;
  logic [CW-1:0] convChan;
  logic convEoc = 0;
  logic [RW-1:0] convResult = 0;
  logic [PW-1:0] resRdAddr = 0;
  logic [RW-1:0] resRdData;
  logic [PW-1:0] curPtr, donePtr;
  logic busy, sseActive, cmpFlag, pauseFlag, torFlag;

  adcq_sequencer #(.NUM_CMDS(NC), .CHAN_W(CW), .RES_W(RW)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // Converter stub and log, acting on the falling edge
  int issueCnt = 0, eocCnt = 0;
  logic [CW-1:0] logChan [512];
  logic [RW-1:0] logRes  [512];
  int stubLat = 3;
  bit stubBusy = 0;
  int stubCd = 0;
  logic [RW-1:0] stubVal = 0;

  always @(negedge clk) begin
    if (convEoc) convEoc = 0;
    if (stubBusy) begin
      if (stubCd <= 0) begin
        convEoc = 1;
        convResult = stubVal;
        logRes[eocCnt & 511] = stubVal;
        eocCnt++;
        stubBusy = 0;
      end else stubCd--;
    end
    if (convStart && rst_n) begin
      logChan[issueCnt & 511] = convChan;
      stubVal = RW'(int'(convChan) * 61 + issueCnt * 7 + 5);
      issueCnt++;
      stubBusy = 1;
      stubCd = stubLat;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wrCmd(input int idx, input bit hold, input logic [CW-1:0] ch);
    cmdWrEn = 1; cmdWrAddr = PW'(idx); cmdWrData = {hold, ch};
    tick();
    cmdWrEn = 0;
  endtask

  task automatic clrFlags(input logic [2:0] m);
    flagClr = m;
    tick();
    flagClr = 0;
  endtask

  task automatic armSingle();
    sseSet = 1;
    tick();
    sseSet = 0;
    tick(); tick();
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin tick(); n++; end
  endtask

  task automatic waitIssues(input int target);
    int n = 0;
    while (issueCnt < target && n < 5000) begin tick(); n++; end
  endtask

  task automatic readSlot(input int idx, output int val);
    resRdAddr = PW'(idx);
    #0.2;
    val = int'(resRdData);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, v;
    logic [CW-1:0] ch [8];
    void'($urandom(32'd20240611));

    repeat (4) tick();
    // R12 reset state
    check("R12 busy", busy, 0);
    check("R12 convStart", convStart, 0);
    check("R12 flags", {torFlag, pauseFlag, cmpFlag}, 0);
    check("R12 ptrs", {curPtr, donePtr}, 0);
    check("R12 sse", sseActive, 0);
    readSlot(5, v);
    check("R12 slot", v, 0);
    rst_n = 1;
    tick();

    // Test A: single scan of four words ending at a marker (R1 R2 R4 R5 R6)
    wrCmd(0, 0, 4'd3); wrCmd(1, 0, 4'd7); wrCmd(2, 0, 4'd1); wrCmd(3, 0, 4'd12);
    wrCmd(4, 0, MRK);
    base = issueCnt;
    gateIn = 1;
    armSingle();
    waitIdle();
    check("R5 issue count", issueCnt - base, 4);
    check("R1 chan0", logChan[base], 3);
    check("R1 chan1", logChan[base+1], 7);
    check("R1 chan2", logChan[base+2], 1);
    check("R1 chan3", logChan[base+3], 12);
    for (int w = 0; w < 4; w++) begin
      readSlot(w, v);
      check("R2 slot", v, int'(logRes[base+w]));
    end
    check("R6 cmp", cmpFlag, 1);
    check("R6 sse cleared", sseActive, 0);
    check("R4 donePtr end", donePtr, 3);
    check("R4 curPtr end", curPtr, 3);
    check("R8 no pause", pauseFlag, 0);
    repeat (30) tick();
    check("R6 no rerun", issueCnt - base, 4);
    check("R11 cmp sticky", cmpFlag, 1);
    clrFlags(3'b111);
    check("R11 cleared", {torFlag, pauseFlag, cmpFlag}, 0);

    // Test B: hold bit on word 1 (R3 R4)
    wrCmd(0, 0, 4'd2); wrCmd(1, 1, 4'd5); wrCmd(2, 0, 4'd9); wrCmd(3, 0, MRK);
    base = issueCnt;
    armSingle();
    while (eocCnt - base < 2) tick();
    repeat (15) tick();
    check("R3 held issues", issueCnt - base, 2);
    check("R3 held busy", busy, 1);
    check("R4 held curPtr", curPtr, 1);
    check("R4 held donePtr", donePtr, 1);
    trigIn = 1; tick(); trigIn = 0;
    waitIdle();
    check("R3 resumed issues", issueCnt - base, 3);
    check("R3 resumed chan", logChan[base+2], 9);
    check("R6 cmp after hold", cmpFlag, 1);
    trigIn = 1; tick(); trigIn = 0;
    repeat (20) tick();
    check("R3 stray trig issues", issueCnt - base, 3);
    check("R3 stray trig ptr", curPtr, 2);
    clrFlags(3'b111);

    // Test C: gate drops mid-conversion then reopens (R7 R8)
    wrCmd(0, 0, 4'd4); wrCmd(1, 0, 4'd6); wrCmd(2, 0, 4'd8); wrCmd(3, 0, 4'd10);
    wrCmd(4, 0, 4'd11); wrCmd(5, 0, 4'd13); wrCmd(6, 0, MRK);
    stubLat = 4;
    base = issueCnt;
    armSingle();
    waitIssues(base + 3);
    gateIn = 0;
    waitIdle();
    tick();
    check("R7 inflight done", eocCnt - base, 3);
    check("R7 no extra issue", issueCnt - base, 3);
    readSlot(2, v);
    check("R7 inflight stored", v, int'(logRes[base+2]));
    check("R7 donePtr", donePtr, 2);
    check("R8 pause set", pauseFlag, 1);
    check("R8 cmp clear", cmpFlag, 0);
    check("R8 sse kept", sseActive, 1);
    gateIn = 1;
    waitIssues(base + 4);
    check("R7 restart word0", logChan[base+3], 4);
    waitIdle();
    check("R7 full pass", issueCnt - base, 9);
    check("R7 cmp", cmpFlag, 1);

    // Test D: continuous scan over two passes (R9 R10 R11)
    wrCmd(0, 0, 4'd1); wrCmd(1, 0, 4'd2); wrCmd(2, 0, 4'd3); wrCmd(3, 0, MRK);
    stubLat = 2;
    clrFlags(3'b111);
    base = issueCnt;
    modeCont = 1;
    waitIssues(base + 4);
    check("R9 cmp first pass", cmpFlag, 1);
    check("R10 no tor yet", torFlag, 0);
    check("R9 restart word0", logChan[base+3], 1);
    waitIssues(base + 7);
    check("R10 tor set", torFlag, 1);
    for (int k = 0; k < 7; k++) check("R9 chan order", logChan[base+k], (k % 3) + 1);
    gateIn = 0;
    waitIdle();
    tick();
    check("R8 no pause in cont", pauseFlag, 0);
    clrFlags(3'b100);
    check("R11 tor cleared", torFlag, 0);
    check("R11 cmp kept", cmpFlag, 1);
    modeCont = 0;
    clrFlags(3'b111);

    // Test E: empty queue (R5)
    wrCmd(0, 0, MRK);
    base = issueCnt;
    gateIn = 1;
    armSingle();
    repeat (10) tick();
    check("R5 empty no issue", issueCnt - base, 0);
    check("R5 empty cmp", cmpFlag, 1);
    check("R6 empty sse", sseActive, 0);

    // Random single-scan queues (R1 R2 R5)
    for (int it = 0; it < 20; it++) begin
      int len;
      len = 1 + int'($urandom_range(0, NC - 1));
      for (int w = 0; w < len; w++) begin
        ch[w] = CW'($urandom_range(0, 14));
        wrCmd(w, 0, ch[w]);
      end
      if (len < NC) wrCmd(len, 0, MRK);
      stubLat = int'($urandom_range(1, 6));
      clrFlags(3'b111);
      base = issueCnt;
      armSingle();
      waitIdle();
      check("R5 rand count", issueCnt - base, len);
      for (int w = 0; w < len; w++) begin
        check("R1 rand chan", logChan[(base+w) & 511], ch[w]);
        readSlot(w, v);
        check("R2 rand slot", v, int'(logRes[(base+w) & 511]));
      end
      check("R6 rand cmp", cmpFlag, 1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule